// File: doc/BRIEF.md
# Residual Time Stamp Generator

This block produces a 4-bit synchronous residual time stamp for a constant-bit-rate circuit-emulation channel. A fast network clock is divided by a parameter (64 by default, 155.52 MHz down to 2.43 MHz) to make a reference tick. A free-running 4-bit residual counter advances on each tick. In the service (line) clock domain, a block timer counts a fixed number of service periods. The default is 3008, which is eight cell payloads. At the end of each block, the timer captures the current residual count into a stamp latch.

The residual count leaves the network domain as a registered Gray code. It passes through a two-flop synchronizer, so the sampled value is always a count that really existed and never a mix of two counts. Host logic in the service domain reads the stamp as one byte. The stamp sits in the low nibble and the high nibble is zero. A sticky flag marks that an unread sample is waiting.

Each clock domain has its own synchronous, active-high reset.

Top module: `srts_stamp_gen`

## Requirements
- R1: The residual counter advances by one, modulo 16, once every REF_DIV network-clock cycles. Between two captures taken under a fixed clock ratio, the stamp therefore advances by the number of elapsed reference ticks modulo 16.
- R2: The register that carries the residual count into the service domain holds a Gray code. Its value changes in at most one bit per network-clock cycle.
- R3: A capture occurs every SVC_DIV service-clock cycles. The first capture lands on the SVC_DIV-th service edge after svc_rst is released.
- R4: The latched stamp keeps its value between captures. Repeated reads with no capture in between return the same byte.
- R5: When rd_en is high at a service edge, rd_data shows the latched stamp from that edge on. Stamp bit 0 (the LSB) is rd_data[0] and stamp bit 3 (the MSB) is rd_data[3].
- R6: rd_data[7:4] is always 0000.
- R7: stamp_valid goes high on the edge that follows a capture. It goes low on the edge where a read happens. If a capture and a read fall in the same cycle, stamp_valid stays high.
- R8: net_rst clears the prescaler and the residual counter. svc_rst clears the block timer, the synchronizer, the stamp latch, rd_data and stamp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| net_clk | input | 1 | Network clock, divided down to make the reference tick |
| net_rst | input | 1 | Synchronous active-high reset for the network domain |
| svc_clk | input | 1 | Service (line) clock |
| svc_rst | input | 1 | Synchronous active-high reset for the service domain |
| rd_en | input | 1 | Host read strobe, service domain |
| rd_data | output | 8 | Read byte: stamp in bits 3:0, zero in bits 7:4 |
| stamp_valid | output | 1 | High while an unread sample is held |

## Verification
A capture shows on stamp_valid one service edge after the timer reaches its last count, which is SVC_DIV edges after reset or after the previous capture. A read shows on rd_data, and clears the flag, on the same edge that samples rd_en. The bench drives rd_en on falling service edges and samples every output on the next falling edge, after exactly one register stage. It counts falling edges to time the period and to place a read on the exact cycle of a capture. The network clock runs at twice the service rate with a fixed phase, so the stamp step between captures is a constant the bench works out from the two parameters.

// File: rtl/srts_pkg.sv
package srts_pkg;
  localparam int STAMP_W = 4;
  localparam int BYTE_W  = 8;
  typedef logic [STAMP_W-1:0] stamp_t;
endpackage

// File: rtl/srts_ref_counter.sv
module srts_ref_counter
  import srts_pkg::*;
#(
  parameter int REF_DIV = 64
) (
  input  logic   clk,
  input  logic   rst,
  output logic   tick,
  output stamp_t bin_q,
  output stamp_t gray_q
);
  localparam int PW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PW'(REF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      pre_q  <= tick ? '0 : pre_q + 1'b1;
      if (tick) bin_q <= bin_q + 1'b1;
      gray_q <= bin_q ^ (bin_q >> 1);
    end
  end
endmodule

// File: rtl/srts_gray_sync.sv
module srts_gray_sync
  import srts_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  stamp_t gray_in,
  output stamp_t bin_out
);
  stamp_t meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out[STAMP_W-1] = sync_q[STAMP_W-1];
  for (genvar i = STAMP_W - 2; i >= 0; i--) begin : g_g2b
    assign bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/srts_block_timer.sv
module srts_block_timer #(
  parameter int SVC_DIV = 3008
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [$clog2(SVC_DIV)-1:0] cnt_q,
  output logic                       cap
);
  localparam int CW = $clog2(SVC_DIV);

  assign cap = (cnt_q == CW'(SVC_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (cap) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/srts_stamp_gen.sv
module srts_stamp_gen
  import srts_pkg::*;
#(
  parameter int REF_DIV = 64,
  parameter int SVC_DIV = 3008
) (
  input  logic              net_clk,
  input  logic              net_rst,
  input  logic              svc_clk,
  input  logic              svc_rst,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              stamp_valid
);
  localparam int CW = $clog2(SVC_DIV);

  logic          ref_tick;
  stamp_t        ref_bin, ref_gray, sync_bin, stamp_q;
  logic [CW-1:0] blk_cnt;
  logic          cap;

  srts_ref_counter #(.REF_DIV(REF_DIV)) u_ref (
    .clk(net_clk), .rst(net_rst), .tick(ref_tick),
    .bin_q(ref_bin), .gray_q(ref_gray)
  );

  srts_gray_sync u_sync (
    .clk(svc_clk), .rst(svc_rst), .gray_in(ref_gray), .bin_out(sync_bin)
  );

  srts_block_timer #(.SVC_DIV(SVC_DIV)) u_timer (
    .clk(svc_clk), .rst(svc_rst), .cnt_q(blk_cnt), .cap(cap)
  );

  always_ff @(posedge svc_clk) begin
    if (svc_rst) begin
      stamp_q     <= '0;
      rd_data     <= '0;
      stamp_valid <= 1'b0;
    end else begin
      if (cap) stamp_q <= sync_bin;
      if (rd_en) rd_data <= {{(BYTE_W-STAMP_W){1'b0}}, stamp_q};
      if (cap)        stamp_valid <= 1'b1;
      else if (rd_en) stamp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/srts_stamp_gen_chk.sv
module srts_stamp_gen_chk #(
  parameter int REF_DIV = 64,
  parameter int SVC_DIV = 3008
) (
  input logic                       net_clk,
  input logic                       net_rst,
  input logic                       svc_clk,
  input logic                       svc_rst,
  input logic                       rd_en,
  input logic [7:0]                 rd_data,
  input logic                       stamp_valid,
  input logic                       ref_tick,
  input logic [3:0]                 ref_bin,
  input logic [3:0]                 ref_gray,
  input logic [$clog2(SVC_DIV)-1:0] blk_cnt,
  input logic                       cap,
  input logic [3:0]                 stamp_q
);
  AST_REF_HOLD: assert property (@(posedge net_clk) disable iff (net_rst)
    !ref_tick |=> $stable(ref_bin)); // R1
  AST_REF_STEP: assert property (@(posedge net_clk) disable iff (net_rst)
    ref_tick |=> ref_bin == $past(ref_bin) + 4'd1); // R1
  AST_GRAY_ONE_BIT: assert property (@(posedge net_clk) disable iff (net_rst)
    $countones(ref_gray ^ $past(ref_gray)) <= 1); // R2
  AST_BLOCK_RANGE: assert property (@(posedge svc_clk) disable iff (svc_rst)
    blk_cnt <= ($clog2(SVC_DIV))'(SVC_DIV - 1)); // R3
  AST_STAMP_HELD: assert property (@(posedge svc_clk) disable iff (svc_rst)
    !cap |=> $stable(stamp_q)); // R4
  AST_READ_DATA: assert property (@(posedge svc_clk) disable iff (svc_rst)
    rd_en |=> rd_data[3:0] == $past(stamp_q)); // R5
  AST_UPPER_ZERO: assert property (@(posedge svc_clk) disable iff (svc_rst)
    rd_data[7:4] == 4'h0); // R6
  AST_VALID_SET: assert property (@(posedge svc_clk) disable iff (svc_rst)
    cap |=> stamp_valid); // R7
  AST_VALID_CLEAR: assert property (@(posedge svc_clk) disable iff (svc_rst)
    rd_en && !cap |=> !stamp_valid); // R7
endmodule

bind srts_stamp_gen srts_stamp_gen_chk #(.REF_DIV(REF_DIV), .SVC_DIV(SVC_DIV)) u_chk (
  .net_clk(net_clk), .net_rst(net_rst), .svc_clk(svc_clk), .svc_rst(svc_rst),
  .rd_en(rd_en), .rd_data(rd_data), .stamp_valid(stamp_valid),
  .ref_tick(ref_tick), .ref_bin(ref_bin), .ref_gray(ref_gray),
  .blk_cnt(blk_cnt), .cap(cap), .stamp_q(stamp_q)
);

// File: tb/test_srts_stamp_gen.sv
`timescale 1ns/1ps
module test_srts_stamp_gen;
  localparam int REF_DIV = 4;
  localparam int SVC_DIV = 40;
  // service period 10 ns, network period 5 ns
  localparam int STEP = ((SVC_DIV * 10) / (5 * REF_DIV)) % 16;

  logic net_clk = 0, svc_clk = 0;
  logic net_rst = 1, svc_rst = 1, rd_en = 0;
  logic [7:0] rd_data;
  logic stamp_valid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 net_clk = ~net_clk;
  always #5   svc_clk = ~svc_clk;

  srts_stamp_gen #(.REF_DIV(REF_DIV), .SVC_DIV(SVC_DIV)) i_srts_stamp_gen (
    .net_clk(net_clk), .net_rst(net_rst), .svc_clk(svc_clk), .svc_rst(svc_rst),
    .rd_en(rd_en), .rd_data(rd_data), .stamp_valid(stamp_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge svc_clk);
      n++;
    end while (!stamp_valid && n < 4 * SVC_DIV);
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_en = 1;
    @(negedge svc_clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge svc_clk);
    check(rd_data == 8'h00, "R8 rd_data after reset", rd_data, 0);
    check(stamp_valid == 1'b0, "R8 valid after reset", stamp_valid, 0);
    net_rst = 0;
    svc_rst = 0;
  endtask

  task automatic t_first_sample();
    int n;
    wait_valid(n);
    check(n == SVC_DIV, "R3 first capture edge", n, SVC_DIV);
    check(stamp_valid == 1'b1, "R7 valid set", stamp_valid, 1);
  endtask

  task automatic t_read_and_deltas();
    logic [7:0] v, prev, again;
    int n;
    do_read(prev);
    check(prev[7:4] == 4'h0, "R6 upper nibble", prev[7:4], 0);
    check(stamp_valid == 1'b0, "R7 valid cleared by read", stamp_valid, 0);
    do_read(again);
    check(again == prev, "R4 stamp held between captures", again, prev);
    check(stamp_valid == 1'b0, "R5 no-capture read keeps valid low", stamp_valid, 0);
    for (int k = 0; k < 3; k++) begin
      wait_valid(n);
      check(n + 2 == SVC_DIV, "R3 capture period", n + 2, SVC_DIV);
      do_read(v);
      check(v[7:4] == 4'h0, "R6 upper nibble", v[7:4], 0);
      check(((v[3:0] - prev[3:0]) & 4'hF) == STEP,
            "R1 R2 R5 stamp step", (v[3:0] - prev[3:0]) & 4'hF, STEP);
      prev = v;
      do_read(v); // keep period bookkeeping: two reads per loop
    end
  endtask

  task automatic t_collision();
    logic [7:0] old;
    int n;
    wait_valid(n);
    do_read(old);                      // clears flag one edge after capture
    repeat (SVC_DIV - 2) @(negedge svc_clk);
    check(stamp_valid == 1'b0, "R7 valid low before capture", stamp_valid, 0);
    rd_en = 1;                         // read on the capture edge
    @(negedge svc_clk);
    rd_en = 0;
    check(stamp_valid == 1'b1, "R7 capture wins over read", stamp_valid, 1);
    check(rd_data == old, "R5 read returns pre-capture stamp", rd_data, old);
  endtask

  task automatic t_mid_reset();
    net_rst = 1;
    svc_rst = 1;
    repeat (2) @(negedge svc_clk);
    check(stamp_valid == 1'b0, "R8 valid cleared by reset", stamp_valid, 0);
    check(rd_data == 8'h00, "R8 rd_data cleared by reset", rd_data, 0);
    net_rst = 0;
    svc_rst = 0;
    t_first_sample();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_sample();
    t_read_and_deltas();
    t_collision();
    t_mid_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule